// File: doc/BRIEF.md
# XOR Coincidence Counter Array

This block is a bank of identical coincidence detectors that share one sampling clock and one measurement window. Each detector gets its own pair of logic-level taps, taken at its own point along two delay paths that run in opposite directions. It combines the pair with an exclusive-or. While the window is open it counts the clock edges on which the two taps disagree. The detector that counts least is the place where the two signals line up best, and the counts rise on both sides of it.

A single start pulse clears every counter and opens the window for a programmed number of clock edges. When the window closes, a sequencer walks the counters in index order. It builds the total of all counts and finds the index of the smallest count, with ties going to the lower index. A done flag then reports that both results are valid. Any counter can be read at any time through one indexed read port with a one-cycle latency.

Top module: `xcc_array`

## Requirements
- R1: Detector i counts an edge only when `tap_a[i]` and `tap_b[i]` hold different values; equal values add nothing.
- R2: A start accepted on edge E0 enables counting on exactly the `win_len` following edges E1..E(win_len), and each detector gains one per enabled edge on which its taps differ.
- R3: With `CNT_W`-bit counters and `win_len` = 2^CNT_W−1 with all taps differing, every counter reads exactly 2^CNT_W−1 and does not wrap.
- R4: A start accepted while idle or done clears every counter, `sum_out` and `min_idx`; a start seen while counting or scanning is ignored and does not change the window.
- R5: Tap values outside the window leave every counter unchanged.
- R6: `done` is 0 from the accepted start edge, is 1 after exactly `N_DET` edges following the last window edge, and stays 1 until the next accepted start.
- R7: While `done` is 1, `sum_out` equals the sum of all detector counts.
- R8: While `done` is 1, `min_idx` is the index of the smallest count; among equal minima the lowest index wins.
- R9: `rd_data` presents the counter selected by `rd_idx` one edge after `rd_idx` is sampled; any `rd_idx` ≥ `N_DET` returns 0.
- R10: `win_len` = 0 opens no counting edge; all counters stay 0, the scan still runs and `done` rises `N_DET` edges after the start edge.
- R11: After reset `done`, `sum_out`, `min_idx`, `rd_data` and every counter are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that clears counters and opens a window |
| win_len | input | CNT_W | Window length in clock edges, sampled with start |
| tap_a | input | N_DET | First tap of each detector pair |
| tap_b | input | N_DET | Second tap of each detector pair |
| rd_idx | input | IDX_W | Detector index for the read port |
| rd_data | output | CNT_W | Selected counter, registered |
| sum_out | output | SUM_W | Total of all counts, valid while done |
| min_idx | output | IDX_W | Index of the smallest count, valid while done |
| done | output | 1 | Results valid; window closed and scan finished |

## Verification
The bench builds the array with six detectors and 10-bit counters. With these values the full-scale window of 1023 edges runs in a short test, so the no-wrap boundary is tested directly. A 4-bit index leaves indices 6 to 15 outside the array, which exercises the zero return for out-of-range reads. The scan delay of six edges can be counted exactly, and ties in the minimum search can be set up with static tap masks. Random tap streams supply irregular per-detector counts, and the bench compares them against totals it builds edge by edge.

// File: rtl/xcc_pkg.sv
// Shared types for the XOR coincidence counter array.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package xcc_pkg;

    // Phases of one measurement: waiting, counting, reducing, results valid.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_SCAN = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

endpackage

// File: rtl/xcc_cell.sv
// One coincidence detector: XOR of its tap pair gates a counter.
// Assumes: clear and count_en are never high together (controller guarantees);
// the window never exceeds 2^CNT_W-1 edges, so the counter cannot wrap.
module xcc_cell #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             count_en,
    input  logic             tap_a,
    input  logic             tap_b,
    output logic [CNT_W-1:0] cnt
);

    logic differ;

    // Mismatch detector between the two taps.
    always_comb differ = tap_a ^ tap_b;

    // Count edges with mismatching taps while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (count_en && differ) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R2: a counter moves by at most one per edge unless cleared.
    a_r2_step_le_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    // R5: outside the window the counter holds.
    a_r5_hold_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(cnt));

endmodule

// File: rtl/xcc_window_ctl.sv
// Measurement sequencer: accepts start, runs the window for win_len edges,
// then steps a scan index over every detector and raises done.
// Assumes: start is ignored unless idle or done; win_len sampled with start.
module xcc_window_ctl
    import xcc_pkg::*;
#(
    parameter int N_DET = 140,
    parameter int CNT_W = 24,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] win_len,
    output logic             clear_cnt,
    output logic             count_en,
    output logic             scan_en,
    output logic             scan_first,
    output logic [IDX_W-1:0] scan_idx,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DET - 1);

    phase_t           phase;
    logic [CNT_W-1:0] ticks;
    logic             accept;

    // Start is honoured only when no measurement is in progress.
    always_comb begin
        accept     = start && (phase == PH_IDLE || phase == PH_DONE);
        clear_cnt  = accept;
        count_en   = (phase == PH_RUN);
        scan_en    = (phase == PH_SCAN);
        scan_first = (scan_idx == '0);
        done       = (phase == PH_DONE);
    end

    // Phase sequencing, window tick countdown and scan stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            ticks    <= '0;
            scan_idx <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (accept) begin
                        ticks    <= win_len;
                        scan_idx <= '0;
                        phase    <= (win_len == '0) ? PH_SCAN : PH_RUN;
                    end
                end
                PH_RUN: begin
                    ticks <= ticks - CNT_W'(1);
                    if (ticks == CNT_W'(1)) begin
                        phase <= PH_SCAN;
                    end
                end
                PH_SCAN: begin
                    if (scan_idx == LAST_IDX) begin
                        scan_idx <= '0;
                        phase    <= PH_DONE;
                    end else begin
                        scan_idx <= scan_idx + IDX_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R4: a running window is never reloaded; it only counts down.
    a_r4_run_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN && ticks > CNT_W'(1)) |=>
            (phase == PH_RUN && ticks == $past(ticks) - CNT_W'(1)));

    // R6: done rises only right after the last scan step.
    a_r6_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(scan_en) && $past(scan_idx) == LAST_IDX));

    // R10: an empty window goes straight to the scan.
    a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_cnt && win_len == '0) |=> (scan_en && !count_en));

    // R2: counting never overlaps the results-valid phase.
    a_r2_no_count_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |-> !done);

endmodule

// File: rtl/xcc_reduce.sv
// Sequential reduction: one counter per scan step; accumulates the total
// and tracks the smallest value with its index (strict less-than, so the
// lowest index wins ties).
// Assumes: scan_first marks the first step of a scan; scan_val is the
// counter selected by scan_idx in the same cycle.
module xcc_reduce #(
    parameter int CNT_W = 24,
    parameter int IDX_W = 9,
    parameter int SUM_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             scan_en,
    input  logic             scan_first,
    input  logic [IDX_W-1:0] scan_idx,
    input  logic [CNT_W-1:0] scan_val,
    output logic [SUM_W-1:0] sum_out,
    output logic [IDX_W-1:0] min_idx
);

    logic [CNT_W-1:0] min_val;

    // Accumulate the total and the running minimum over the scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out <= '0;
            min_val <= '0;
            min_idx <= '0;
        end else if (clear) begin
            sum_out <= '0;
            min_val <= '0;
            min_idx <= '0;
        end else if (scan_en) begin
            if (scan_first) begin
                sum_out <= SUM_W'(scan_val);
                min_val <= scan_val;
                min_idx <= scan_idx;
            end else begin
                sum_out <= sum_out + SUM_W'(scan_val);
                if (scan_val < min_val) begin
                    min_val <= scan_val;
                    min_idx <= scan_idx;
                end
            end
        end
    end

    // R7: after the first step the total never shrinks during a scan.
    a_r7_sum_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !scan_first) |=> (sum_out >= $past(sum_out)));

    // R8: the tracked minimum never increases after the first step.
    a_r8_min_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !scan_first) |=> (min_val <= $past(min_val)));

endmodule

// File: rtl/xcc_array.sv
// XOR coincidence counter array, top level.
// Holds N_DET detectors counting in one common window, a sequencer, a
// sequential sum/minimum reduction and a registered indexed read port.
// Assumes: tap inputs are already synchronous to clk.
module xcc_array #(
    parameter int N_DET = 140,
    parameter int CNT_W = 24,
    parameter int IDX_W = $clog2(N_DET) + 1,
    parameter int SUM_W = CNT_W + $clog2(N_DET)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] win_len,
    input  logic [N_DET-1:0] tap_a,
    input  logic [N_DET-1:0] tap_b,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data,
    output logic [SUM_W-1:0] sum_out,
    output logic [IDX_W-1:0] min_idx,
    output logic             done
);

    logic [CNT_W-1:0] cnt [N_DET];
    logic             clear_cnt;
    logic             count_en;
    logic             scan_en;
    logic             scan_first;
    logic [IDX_W-1:0] scan_idx;
    logic [CNT_W-1:0] scan_val;
    logic [CNT_W-1:0] rd_sel;

    xcc_window_ctl #(
        .N_DET (N_DET),
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .win_len    (win_len),
        .clear_cnt  (clear_cnt),
        .count_en   (count_en),
        .scan_en    (scan_en),
        .scan_first (scan_first),
        .scan_idx   (scan_idx),
        .done       (done)
    );

    for (genvar g = 0; g < N_DET; g++) begin : g_det
        xcc_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear_cnt),
            .count_en (count_en),
            .tap_a    (tap_a[g]),
            .tap_b    (tap_b[g]),
            .cnt      (cnt[g])
        );
    end

    // Select the counter addressed by the scan and by the read port;
    // an index outside the array selects zero.
    always_comb begin
        scan_val = '0;
        rd_sel   = '0;
        for (int i = 0; i < N_DET; i++) begin
            if (scan_idx == IDX_W'(i)) scan_val = cnt[i];
            if (rd_idx == IDX_W'(i))   rd_sel   = cnt[i];
        end
    end

    xcc_reduce #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W),
        .SUM_W (SUM_W)
    ) u_reduce (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_cnt),
        .scan_en    (scan_en),
        .scan_first (scan_first),
        .scan_idx   (scan_idx),
        .scan_val   (scan_val),
        .sum_out    (sum_out),
        .min_idx    (min_idx)
    );

    // Register the read port output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_sel;
        end
    end

    // R9: an index past the array reads back zero on the next edge.
    a_r9_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= IDX_W'(N_DET)) |=> (rd_data == '0));

    // R8: the reported minimum index always names a real detector.
    a_r8_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (min_idx < IDX_W'(N_DET)));

endmodule

// File: tb/test_xcc_array.sv
// Directed bench for xcc_array: one task per scenario, each self-checking.
module test_xcc_array;

    localparam int N     = 6;
    localparam int CW    = 10;
    localparam int IW    = $clog2(N) + 1;
    localparam int SW    = CW + $clog2(N);
    localparam int MAXW  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] win_len = '0;
    logic [N-1:0]  tap_a = '0;
    logic [N-1:0]  tap_b = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [CW-1:0] rd_data;
    logic [SW-1:0] sum_out;
    logic [IW-1:0] min_idx;
    logic          done;

    int checks = 0;
    int bad    = 0;
    int exp_cnt [N];
    logic [15:0] lfsr = 16'hACE1;

    xcc_array #(.N_DET(N), .CNT_W(CW)) i_xcc_array (
        .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
        .tap_a(tap_a), .tap_b(tap_b), .rd_idx(rd_idx), .rd_data(rd_data),
        .sum_out(sum_out), .min_idx(min_idx), .done(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Read one counter; called and returning at a negedge.
    task automatic rd(input int idx, output int val);
        rd_idx = IW'(idx);
        @(posedge clk);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    // Run one window. kind 0: static mask on tap_a, tap_b=0; kind 1: random.
    // Returns the number of edges from the last window edge to done.
    task automatic run_window(input int len, input int kind,
                              input logic [N-1:0] mask, output int lat);
        for (int i = 0; i < N; i++) exp_cnt[i] = 0;
        start   = 1'b1;
        win_len = CW'(len);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < len; k++) begin
            if (kind == 0) begin
                tap_a = mask;
                tap_b = '0;
            end else begin
                lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tap_a = lfsr[N-1:0];
                tap_b = lfsr[2*N-1:N];
            end
            for (int i = 0; i < N; i++) if (tap_a[i] != tap_b[i]) exp_cnt[i]++;
            @(posedge clk);
            @(negedge clk);
        end
        tap_a = '1;
        tap_b = '0;
        lat = 0;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
    endtask

    // Compare counters, sum and minimum index with bench expectations.
    task automatic check_results(input string tag);
        int v;
        int s;
        int mi;
        s  = 0;
        mi = 0;
        for (int i = 0; i < N; i++) begin
            rd(i, v);
            chk({tag, " R1/R2 count"}, v, exp_cnt[i]);
            s += exp_cnt[i];
            if (exp_cnt[i] < exp_cnt[mi]) mi = i;
        end
        chk({tag, " R7 sum"}, int'(sum_out), s);
        chk({tag, " R8 min index"}, int'(min_idx), mi);
    endtask

    task automatic t_reset();
        int v;
        chk("R11 done after reset", int'(done), 0);
        chk("R11 sum after reset", int'(sum_out), 0);
        chk("R11 min_idx after reset", int'(min_idx), 0);
        chk("R11 rd_data after reset", int'(rd_data), 0);
        for (int i = 0; i < N; i++) begin
            rd(i, v);
            chk("R11 counter after reset", v, 0);
        end
    endtask

    task automatic t_static();
        int lat;
        run_window(17, 0, 6'b101101, lat);
        chk("R6 done latency", lat, N);
        check_results("static tie");
        chk("R8 tie lowest index", int'(min_idx), 1);
    endtask

    task automatic t_random();
        int lat;
        run_window(200, 1, '0, lat);
        chk("R6 done latency random", lat, N);
        check_results("random");
    endtask

    task automatic t_restart_ignored();
        int lat;
        int v;
        for (int i = 0; i < N; i++) exp_cnt[i] = 30;
        start   = 1'b1;
        win_len = CW'(30);
        tap_a   = '1;
        tap_b   = '0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R6 done low after start", int'(done), 0);
        for (int k = 0; k < 30; k++) begin
            if (k == 10) begin
                start   = 1'b1;
                win_len = CW'(5);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
        lat   = 0;
        while (!done && lat < 100) begin
            if (lat == 2) start = 1'b1;
            else start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        chk("R4 ignored start keeps latency", lat, N);
        check_results("R4 restart ignored");
        rd(0, v);
        chk("R4 window not reloaded", v, 30);
    endtask

    task automatic t_quiet();
        int v;
        tap_a = 6'b110011;
        tap_b = 6'b001100;
        repeat (20) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            rd(i, v);
            chk("R5 counter unchanged outside window", v, exp_cnt[i]);
        end
        chk("R6 done held", int'(done), 1);
    endtask

    task automatic t_equal_taps();
        int lat;
        tap_a = '0;
        tap_b = '0;
        run_window(12, 0, '0, lat);
        check_results("R1 equal taps");
    endtask

    task automatic t_zero_len();
        int lat;
        run_window(0, 0, '1, lat);
        chk("R10 done latency empty window", lat, N);
        check_results("R10 empty window");
    endtask

    task automatic t_max();
        int lat;
        run_window(MAXW, 0, '1, lat);
        check_results("R3 full scale");
        chk("R3 sum full scale", int'(sum_out), N * MAXW);
    endtask

    task automatic t_read();
        int v;
        run_window(9, 0, 6'b010000, lat_dummy);
        rd(4, v);
        chk("R9 read idx4", v, 9);
        rd_idx = IW'(0);
        chk("R9 latency old value held", int'(rd_data), 9);
        @(posedge clk);
        @(negedge clk);
        chk("R9 latency new value", int'(rd_data), 0);
        for (int i = N; i < (1 << IW); i++) begin
            rd(i, v);
            chk("R9 out-of-range zero", v, 0);
        end
    endtask

    int lat_dummy;

    initial begin
        #2_000_000;
        checks++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_static();
        t_random();
        t_restart_ignored();
        t_quiet();
        t_equal_taps();
        t_zero_len();
        t_max();
        t_read();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule